// File: doc/BRIEF.md
# Paged Address Translator with Access Protection

This block turns a virtual address into a physical address through a small page table held in registers. The virtual address splits into a page number in its upper bits and a byte offset within the page in its lower bits. The page number selects one table entry. The entry's frame number is placed above the unchanged offset to form the physical address. By default the virtual address is 8 bits wide, pages are 64 bytes, and the physical address is 10 bits wide. That gives 4 virtual pages and 16 physical frames.

Each table entry also carries four permission flags: present, readable, writable and executable. Every request names its access kind, which is a load, a store or an instruction fetch. The block checks the access against the selected entry's flags. If the check fails, the block raises a fault and the physical address output is held at zero. The table is loaded one entry at a time through a configuration write port. The response is registered and appears one cycle after the request.

Top module: `page_xlat`

## Requirements
- R1: After reset, `rsp_valid_o` and `rsp_fault_o` are low, and every table entry is not present, so any request made before configuration faults.
- R2: A request presented with `req_valid_i` high in cycle N gives `rsp_valid_o` high in cycle N+1. If there is no fault, `rsp_paddr_o = {frame, vaddr[OFF_W-1:0]}`, where the frame comes from the entry indexed by `vaddr[VA_W-1:OFF_W]`.
- R3: An access to an entry whose present flag (`cfg_flags_i[3]`) is clear faults, whatever its other flags are.
- R4: A load (`req_acc_i` = 0) faults when the entry's readable flag (`cfg_flags_i[2]`) is clear.
- R5: A store (`req_acc_i` = 1) faults when the entry's writable flag (`cfg_flags_i[1]`) is clear.
- R6: A fetch (`req_acc_i` = 2) faults when the entry's executable flag (`cfg_flags_i[0]`) is clear.
- R7: The access code 3 is reserved and always faults.
- R8: Whenever `rsp_fault_o` is high, `rsp_paddr_o` is zero.
- R9: A configuration write in cycle N first affects requests made in cycle N+1. A request made in the same cycle as the write is judged against the old entry.
- R10: With frames [2,5,1,8] loaded into pages 0..3, a load from virtual address 241 gives physical address 561.
- R11: A cycle with `req_valid_i` low leaves `rsp_valid_o` and `rsp_fault_o` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write one table entry |
| cfg_idx_i | input | VA_W-OFF_W | Index of the entry to write |
| cfg_ppn_i | input | PPN_W | Frame number to store |
| cfg_flags_i | input | 4 | Flags: [3] present, [2] readable, [1] writable, [0] executable |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | VA_W | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_paddr_o | output | PPN_W+OFF_W | Physical address, zero on a fault |
| rsp_fault_o | output | 1 | Permission or presence fault |

## Verification
A table update and a translation through the same entry can fall in the same cycle. The bench provokes this by driving a configuration write and a request to that page on one clock edge. The new flags and frame are chosen so that they would give a different fault outcome and a different address. The response must match the old entry. A second request one cycle later must match the new entry, and the bench judges both against its own copy of the table.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic present;
    logic rd;
    logic wr;
    logic ex;
  } pte_flags_t;

  localparam int unsigned FLAGS_W = $bits(pte_flags_t);
endpackage

// File: rtl/pte_table.sv
module pte_table
  import page_xlat_pkg::*;
#(
  parameter int unsigned VPN_W = 2,
  parameter int unsigned PPN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [VPN_W-1:0] wr_idx_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  pte_flags_t       wr_flags_i,
  input  logic [VPN_W-1:0] rd_idx_i,
  output logic [PPN_W-1:0] rd_ppn_o,
  output pte_flags_t       rd_flags_o
);
  localparam int unsigned N_PAGES = 1 << VPN_W;

  logic [PPN_W-1:0] ppn_q   [N_PAGES];
  pte_flags_t       flags_q [N_PAGES];

  for (genvar g = 0; g < N_PAGES; g++) begin : g_entry
    logic sel;
    assign sel = we_i && (wr_idx_i == VPN_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ppn_q[g]   <= '0;
        flags_q[g] <= '0;
      end else if (sel) begin
        ppn_q[g]   <= wr_ppn_i;
        flags_q[g] <= wr_flags_i;
      end
    end
  end

  assign rd_ppn_o   = ppn_q[rd_idx_i];
  assign rd_flags_o = flags_q[rd_idx_i];
endmodule

// File: rtl/perm_check.sv
module perm_check
  import page_xlat_pkg::*;
(
  input  pte_flags_t flags_i,
  input  acc_e       acc_i,
  output logic       fault_o
);
  logic allowed;

  always_comb begin
    unique case (acc_i)
      ACC_LOAD:  allowed = flags_i.rd;
      ACC_STORE: allowed = flags_i.wr;
      ACC_FETCH: allowed = flags_i.ex;
      default:   allowed = 1'b0;
    endcase
    fault_o = !(flags_i.present && allowed);
  end
endmodule

// File: rtl/page_xlat.sv
module page_xlat
  import page_xlat_pkg::*;
#(
  parameter int unsigned VA_W  = 8,
  parameter int unsigned OFF_W = 6,
  parameter int unsigned PPN_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [VA_W-OFF_W-1:0]  cfg_idx_i,
  input  logic [PPN_W-1:0]       cfg_ppn_i,
  input  logic [3:0]             cfg_flags_i,
  input  logic                   req_valid_i,
  input  logic [VA_W-1:0]        req_vaddr_i,
  input  logic [1:0]             req_acc_i,
  output logic                   rsp_valid_o,
  output logic [PPN_W+OFF_W-1:0] rsp_paddr_o,
  output logic                   rsp_fault_o
);
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned PA_W  = PPN_W + OFF_W;

  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;
  logic [PPN_W-1:0] ent_ppn;
  pte_flags_t       ent_flags;
  logic             fault_d;
  logic [PA_W-1:0]  paddr_d;

  assign vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign off = req_vaddr_i[OFF_W-1:0];

  pte_table #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_ppn_i   (cfg_ppn_i),
    .wr_flags_i (pte_flags_t'(cfg_flags_i)),
    .rd_idx_i   (vpn),
    .rd_ppn_o   (ent_ppn),
    .rd_flags_o (ent_flags)
  );

  perm_check u_perm (
    .flags_i (ent_flags),
    .acc_i   (acc_e'(req_acc_i)),
    .fault_o (fault_d)
  );

  assign paddr_d = fault_d ? '0 : {ent_ppn, off};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= req_valid_i && fault_d;
      rsp_paddr_o <= req_valid_i ? paddr_d : '0;
    end
  end
endmodule

// File: rtl/page_xlat_chk.sv
module page_xlat_chk #(
  parameter int unsigned VA_W  = 8,
  parameter int unsigned OFF_W = 6,
  parameter int unsigned PPN_W = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic [VA_W-1:0]        req_vaddr_i,
  input logic [1:0]             req_acc_i,
  input logic                   rsp_valid_o,
  input logic [PPN_W+OFF_W-1:0] rsp_paddr_o,
  input logic                   rsp_fault_o
);
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_offset_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_fault_o || rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0])));

  p_rsvd_faults_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_acc_i == 2'd3) |=> rsp_fault_o);

  p_fault_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_paddr_o == '0 && rsp_valid_o));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_fault_o));
endmodule

bind page_xlat page_xlat_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .req_acc_i   (req_acc_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_fault_o (rsp_fault_o)
);

// File: tb/page_xlat_tb.sv
module page_xlat_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_idx_i = '0;
  logic [3:0] cfg_ppn_i = '0;
  logic [3:0] cfg_flags_i = '0;
  logic       req_valid_i = 1'b0;
  logic [7:0] req_vaddr_i = '0;
  logic [1:0] req_acc_i = '0;
  logic       rsp_valid_o;
  logic [9:0] rsp_paddr_o;
  logic       rsp_fault_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] m_ppn [4];
  logic [3:0] m_flg [4];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  page_xlat u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_ppn_i(cfg_ppn_i), .cfg_flags_i(cfg_flags_i),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_acc_i(req_acc_i),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o), .rsp_fault_o(rsp_fault_o)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_fault(input logic [7:0] va, input logic [1:0] acc);
    logic [3:0] f;
    logic ok;
    f = m_flg[va[7:6]];
    case (acc)
      2'd0: ok = f[2];
      2'd1: ok = f[1];
      2'd2: ok = f[0];
      default: ok = 1'b0;
    endcase
    return !(f[3] && ok);
  endfunction

  function automatic logic [11:0] exp_rsp(input logic [7:0] va, input logic [1:0] acc);
    logic flt;
    flt = exp_fault(va, acc);
    return {1'b1, flt, flt ? 10'd0 : {m_ppn[va[7:6]], va[5:0]}};
  endfunction

  task automatic cfg(input logic [1:0] idx, input logic [3:0] ppn, input logic [3:0] flg);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_ppn_i = ppn; cfg_flags_i = flg;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    m_ppn[idx] = ppn; m_flg[idx] = flg;
  endtask

  task automatic xlat(input string req, input logic [7:0] va, input logic [1:0] acc);
    logic [11:0] e;
    e = exp_rsp(va, acc);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; req_acc_i = acc;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(req, {rsp_valid_o, rsp_fault_o, rsp_paddr_o}, e);
  endtask

  task automatic t_reset;
    check("R1 idle after reset", {10'd0, rsp_valid_o, rsp_fault_o}, 12'd0);
    xlat("R1 unconfigured faults", 8'h10, 2'd0);
  endtask

  task automatic t_example;
    cfg(2'd0, 4'd2, 4'b1111);
    cfg(2'd1, 4'd5, 4'b1111);
    cfg(2'd2, 4'd1, 4'b1111);
    cfg(2'd3, 4'd8, 4'b1111);
    xlat("R10 va 241", 8'd241, 2'd0);
    check("R10 pa 561", {2'b0, rsp_paddr_o}, 12'd561);
    xlat("R2 page0 offset0", 8'h00, 2'd1);
    xlat("R2 page1 max offset", 8'h7f, 2'd2);
    xlat("R2 page2", 8'h95, 2'd0);
  endtask

  task automatic t_perms;
    cfg(2'd0, 4'd3, 4'b0111);
    xlat("R3 not present load", 8'h05, 2'd0);
    xlat("R3 not present fetch", 8'h05, 2'd2);
    cfg(2'd1, 4'd9, 4'b1011);
    xlat("R4 load no read", 8'h44, 2'd0);
    xlat("R4 store ok", 8'h44, 2'd1);
    cfg(2'd2, 4'd12, 4'b1101);
    xlat("R5 store no write", 8'h88, 2'd1);
    xlat("R5 load ok", 8'h88, 2'd0);
    cfg(2'd3, 4'd15, 4'b1110);
    xlat("R6 fetch no exec", 8'hff, 2'd2);
    xlat("R6 store ok", 8'hff, 2'd1);
    xlat("R7 reserved code", 8'hff, 2'd3);
    check("R8 paddr zero on fault", {2'b0, rsp_paddr_o}, 12'd0);
  endtask

  task automatic t_same_cycle;
    logic [11:0] e_old;
    logic [11:0] e_new;
    cfg(2'd1, 4'd6, 4'b1100);
    e_old = exp_rsp(8'h4a, 2'd1);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 2'd1; cfg_ppn_i = 4'd11; cfg_flags_i = 4'b1110;
    req_valid_i = 1'b1; req_vaddr_i = 8'h4a; req_acc_i = 2'd1;
    @(negedge clk_i);
    cfg_we_i = 1'b0; m_ppn[1] = 4'd11; m_flg[1] = 4'b1110;
    e_new = exp_rsp(8'h4a, 2'd1);
    check("R9 same-cycle uses old entry", {rsp_valid_o, rsp_fault_o, rsp_paddr_o}, e_old);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R9 next cycle uses new entry", {rsp_valid_o, rsp_fault_o, rsp_paddr_o}, e_new);
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_acc_i = 2'd3;
    @(negedge clk_i);
    check("R11 idle gives no response", {10'd0, rsp_valid_o, rsp_fault_o}, 12'd0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_ppn[i] = '0; m_flg[i] = '0; end
    #(CLK_PERIOD*2 + 2);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_example;
    t_perms;
    t_same_cycle;
    t_idle;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule